// File: doc/BRIEF.md
# Locked Address Translation Window

This block holds one address-translation entry that a host programs through four 32-bit registers. The entry has a window base, a window size, a 36-bit destination base and a valid bit. The destination base is made of a 32-bit bridge register plus four upper bits that sit in the control register. The target code is fixed. When the entry is enabled, every request address is compared with the window. An address inside the window is moved into the destination space. The block drives a hit flag, the 36-bit translated address and the target code, all combinationally from the request address.

Enabling the entry freezes its configuration. While the valid bit is set, the block ignores host writes to the base, the size, the bridge base and the upper address bits. The host can still clear the valid bit, and doing so releases the freeze. A disable fuse input holds the entry off and reports this through a read-only status bit.

Top module: `xlat_window`

## Requirements
- R1: After reset the base, size and bridge registers read 0. The control register reads 0x0000_1008, which is valid 0, target 100 and the host-only flag set. No request hits.
- R2: The registers are selected by regAddr[3:2]: 0 is control, 1 is window base, 2 is window size, 3 is bridge base. A write with regAddr[1:0] not equal to 0 is ignored. A register write takes effect at the clock edge on which regWrEn is high.
- R3: Control bit 0 is valid. Bits 3:1 always read 100. Bits 11:8 are the writable upper address bits. Bit 12 always reads 1. Bit 13 reads the fuse. All other bits read 0 whatever the host writes.
- R4: A request hits only when valid is 1, size is non-zero and base <= reqAddr < base + size.
- R5: The upper bound base + size is computed in 33 bits, so a window that reaches the top of the 32-bit space does not wrap around to low addresses.
- R6: On a hit, xlatAddr = {upper, bridge} + (reqAddr - base), taken modulo 2^36, and xlatTarget = 100. On a miss, both outputs are 0.
- R7: While valid is 1, host writes to base, size, bridge and the control upper bits are ignored.
- R8: Writing 0 to the valid bit clears it and makes the configuration writable again.
- R9: While fuseDisable is 1, valid reads 0, the host cannot set it, control bit 13 reads 1 and no request hits. A valid bit that was set is cleared at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fuseDisable | input | 1 | Disables the entry while high |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 4 | Host register byte offset |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| reqAddr | input | 32 | Request address to translate |
| reqHit | output | 1 | Request falls inside the enabled window |
| xlatAddr | output | 36 | Translated address, 0 on a miss |
| xlatTarget | output | 3 | Target code on a hit, 0 on a miss |

## Verification
The embedded assertions check the following on every cycle:
- The freeze holds: base, size, bridge and upper bits stay stable across any cycle that starts with valid set.
- A high fuse blocks hits and clears the stored valid bit by the next edge.
- A zero size, or an entry that is not valid, never produces a hit.

The directed scenarios are needed for the behaviour that depends on exact values:
- the window edges, including the window that touches the top of the 32-bit space;
- the 36-bit translation arithmetic and its wrap;
- the read-only control fields;
- the misaligned-write rule;
- the release of the freeze when valid is cleared.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int REG_W   = 32;
  localparam int REG_AW  = 4;

  localparam int VALID_BIT    = 0;
  localparam int TGT_LO       = 1;
  localparam int TGT_W        = 3;
  localparam int UPPER_LO     = 8;
  localparam int HOSTONLY_BIT = 12;
  localparam int FUSE_BIT     = 13;

  localparam logic [TGT_W-1:0] TARGET_DDR = 3'b100;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_BASE   = 2'd1,
    SEL_SIZE   = 2'd2,
    SEL_BRIDGE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    ldBase;
    logic    ldSize;
    logic    ldBridge;
    logic    ldUpper;
    logic    wrValid;
    logic    validVal;
    regSel_e rdSel;
  } xwStrobe_t;
endpackage

// File: rtl/xw_ctrl.sv
module xw_ctrl
  import xw_pkg::*;
(
  input  logic        regWrEn,
  input  logic [1:0]  regWord,
  input  logic        wrValidBit,
  input  logic        validQ,
  input  logic        fuseDisable,
  output xwStrobe_t   st
);
  regSel_e sel;
  logic    locked;

  always_comb begin
    sel         = regSel_e'(regWord);
    locked      = validQ;
    st.rdSel    = sel;
    st.ldBase   = regWrEn && (sel == SEL_BASE)   && !locked;
    st.ldSize   = regWrEn && (sel == SEL_SIZE)   && !locked;
    st.ldBridge = regWrEn && (sel == SEL_BRIDGE) && !locked;
    st.wrValid  = regWrEn && (sel == SEL_CTRL);
    st.ldUpper  = regWrEn && (sel == SEL_CTRL)   && !locked;
    st.validVal = wrValidBit && !fuseDisable;
  end
endmodule

// File: rtl/xw_datapath.sv
module xw_datapath
  import xw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int UPPER_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xwStrobe_t                   st,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        fuseDisable,
  input  logic [DATA_W-1:0]           reqAddr,
  output logic [DATA_W-1:0]           rdData,
  output logic                        validQ,
  output logic                        reqHit,
  output logic [DATA_W+UPPER_W-1:0]   xlatAddr,
  output logic [TGT_W-1:0]            xlatTarget
);
  localparam int XLAT_W = DATA_W + UPPER_W;

  logic [DATA_W-1:0]  baseQ, sizeQ, bridgeQ;
  logic [UPPER_W-1:0] upperQ;
  logic               validEff;
  logic [DATA_W:0]    endSum;
  logic [DATA_W-1:0]  offset;
  logic [XLAT_W-1:0]  xlatSum;
  logic               inWin;
  logic [DATA_W-1:0]  ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      sizeQ   <= '0;
      bridgeQ <= '0;
      upperQ  <= '0;
      validQ  <= 1'b0;
    end else begin
      if (st.ldBase)   baseQ   <= wrData;
      if (st.ldSize)   sizeQ   <= wrData;
      if (st.ldBridge) bridgeQ <= wrData;
      if (st.ldUpper)  upperQ  <= wrData[UPPER_LO +: UPPER_W];
      if (fuseDisable)     validQ <= 1'b0;
      else if (st.wrValid) validQ <= st.validVal;
    end
  end

  always_comb begin
    validEff = validQ && !fuseDisable;
    endSum   = {1'b0, baseQ} + {1'b0, sizeQ};
    inWin    = validEff && (sizeQ != '0) && (reqAddr >= baseQ)
               && ({1'b0, reqAddr} < endSum);
    offset   = reqAddr - baseQ;
    xlatSum  = {upperQ, bridgeQ} + {{UPPER_W{1'b0}}, offset};
    reqHit     = inWin;
    xlatAddr   = inWin ? xlatSum : '0;
    xlatTarget = inWin ? TARGET_DDR : '0;
  end

  always_comb begin
    ctrlWord                        = '0;
    ctrlWord[VALID_BIT]             = validEff;
    ctrlWord[TGT_LO +: TGT_W]       = TARGET_DDR;
    ctrlWord[UPPER_LO +: UPPER_W]   = upperQ;
    ctrlWord[HOSTONLY_BIT]          = 1'b1;
    ctrlWord[FUSE_BIT]              = fuseDisable;
    unique case (st.rdSel)
      SEL_CTRL:   rdData = ctrlWord;
      SEL_BASE:   rdData = baseQ;
      SEL_SIZE:   rdData = sizeQ;
      SEL_BRIDGE: rdData = bridgeQ;
      default:    rdData = '0;
    endcase
  end

  // R7: configuration frozen across any cycle that begins with valid set
  p_lock_cfg_r7: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> ($stable(baseQ) && $stable(sizeQ) && $stable(bridgeQ) && $stable(upperQ)));

  // R9: fuse blocks hits and clears the stored valid bit
  p_fuse_nohit_r9: assert property (@(posedge clk) disable iff (!rstN)
    fuseDisable |-> !reqHit);
  p_fuse_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    fuseDisable |=> !validQ);

  // R4: hits need a valid entry and a non-empty window
  p_hit_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqHit |-> validQ);
  p_zero_size_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sizeQ == '0) |-> !reqHit);
endmodule

// File: rtl/xlat_window.sv
module xlat_window
  import xw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int UPPER_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      fuseDisable,
  input  logic                      regWrEn,
  input  logic [REG_AW-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  input  logic [DATA_W-1:0]         reqAddr,
  output logic                      reqHit,
  output logic [DATA_W+UPPER_W-1:0] xlatAddr,
  output logic [TGT_W-1:0]          xlatTarget
);
  xwStrobe_t st;
  logic      validQ;
  logic      alignedWr;

  assign alignedWr = regWrEn && (regAddr[1:0] == 2'b00);

  xw_ctrl ctrl_i (
    .regWrEn     (alignedWr),
    .regWord     (regAddr[3:2]),
    .wrValidBit  (regWrData[VALID_BIT]),
    .validQ      (validQ),
    .fuseDisable (fuseDisable),
    .st          (st)
  );

  xw_datapath #(.DATA_W(DATA_W), .UPPER_W(UPPER_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .wrData      (regWrData),
    .fuseDisable (fuseDisable),
    .reqAddr     (reqAddr),
    .rdData      (regRdData),
    .validQ      (validQ),
    .reqHit      (reqHit),
    .xlatAddr    (xlatAddr),
    .xlatTarget  (xlatTarget)
  );
endmodule

// File: tb/xlat_window_tb_top.sv
module xlat_window_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fuseDisable = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] reqAddr = '0;
  logic        reqHit;
  logic [35:0] xlatAddr;
  logic [2:0]  xlatTarget;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xlat_window dut_i (
    .clk(clk), .rstN(rstN), .fuseDisable(fuseDisable),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .reqAddr(reqAddr), .reqHit(reqHit),
    .xlatAddr(xlatAddr), .xlatTarget(xlatTarget)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    regAddr = a; #1;
    chk(req, {4'h0, regRdData}, {4'h0, exp});
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic hit,
                       input logic [35:0] xa);
    reqAddr = a; #1;
    chk(req, {35'h0, reqHit}, {35'h0, hit});
    chk(req, xlatAddr, xa);
    chk(req, {33'h0, xlatTarget}, hit ? 36'h4 : 36'h0);
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 4'h0, 32'h0000_1008);
    rdchk("R1 base", 4'h4, 32'h0);
    rdchk("R1 size", 4'h8, 32'h0);
    rdchk("R1 bridge", 4'hC, 32'h0);
    probe("R1 nohit", 32'h0, 1'b0, 36'h0);
  endtask

  task automatic t_regs;
    wr(4'h4, 32'h1000_0000);
    wr(4'h8, 32'h0000_1000);
    wr(4'hC, 32'h8000_0000);
    wr(4'h0, 32'hFFFF_F3F0);
    rdchk("R2 base", 4'h4, 32'h1000_0000);
    rdchk("R2 size", 4'h8, 32'h0000_1000);
    rdchk("R2 bridge", 4'hC, 32'h8000_0000);
    rdchk("R3 ctrl fixed fields", 4'h0, 32'h0000_1308);
    wr(4'h5, 32'hDEAD_BEEF);
    rdchk("R2 misaligned ignored", 4'h4, 32'h1000_0000);
  endtask

  task automatic t_hit;
    wr(4'h0, 32'h0000_0301);
    rdchk("R3 valid set", 4'h0, 32'h0000_1309);
    probe("R6 inside", 32'h1000_0010, 1'b1, 36'h3_8000_0010);
    probe("R4 first", 32'h1000_0000, 1'b1, 36'h3_8000_0000);
    probe("R4 last", 32'h1000_0FFF, 1'b1, 36'h3_8000_0FFF);
    probe("R4 end excluded", 32'h1000_1000, 1'b0, 36'h0);
    probe("R4 below", 32'h0FFF_FFFF, 1'b0, 36'h0);
  endtask

  task automatic t_lock;
    wr(4'h4, 32'h2000_0000);
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h0);
    wr(4'h0, 32'h0000_0F01);
    rdchk("R7 base locked", 4'h4, 32'h1000_0000);
    rdchk("R7 size locked", 4'h8, 32'h0000_1000);
    rdchk("R7 bridge locked", 4'hC, 32'h8000_0000);
    rdchk("R7 upper locked", 4'h0, 32'h0000_1309);
    probe("R7 still maps", 32'h1000_0010, 1'b1, 36'h3_8000_0010);
  endtask

  task automatic t_unlock;
    wr(4'h0, 32'h0000_0300);
    rdchk("R8 valid cleared", 4'h0, 32'h0000_1308);
    probe("R8 no hit", 32'h1000_0010, 1'b0, 36'h0);
    wr(4'h4, 32'h2000_0000);
    rdchk("R8 writable again", 4'h4, 32'h2000_0000);
  endtask

  task automatic t_zero_size;
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h0000_0001);
    probe("R4 zero size", 32'h2000_0000, 1'b0, 36'h0);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_top;
    wr(4'h4, 32'hFFFF_F000);
    wr(4'h8, 32'h0000_2000);
    wr(4'hC, 32'h0);
    wr(4'h0, 32'h0000_0001);
    probe("R5 top hit", 32'hFFFF_FFFF, 1'b1, 36'h0_0000_0FFF);
    probe("R5 no wrap", 32'h0000_0800, 1'b0, 36'h0);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_wrap36;
    wr(4'h4, 32'h0);
    wr(4'h8, 32'h0000_0100);
    wr(4'hC, 32'hFFFF_FFF0);
    wr(4'h0, 32'h0000_0F01);
    probe("R6 36-bit wrap", 32'h0000_0020, 1'b1, 36'h0_0000_0010);
    wr(4'h0, 32'h0000_0000);
  endtask

  task automatic t_fuse;
    @(negedge clk); fuseDisable = 1'b1;
    wr(4'h0, 32'h0000_0001);
    rdchk("R9 cannot set", 4'h0, 32'h0000_3008);
    probe("R9 no hit", 32'h0000_0010, 1'b0, 36'h0);
    @(negedge clk); fuseDisable = 1'b0;
    wr(4'h0, 32'h0000_0001);
    probe("R9 hit without fuse", 32'h0000_0010, 1'b1, 36'h0_FFFF_FFF0 + 36'h10);
    @(negedge clk); fuseDisable = 1'b1; #1;
    chk("R9 hit drops", {35'h0, reqHit}, 36'h0);
    @(negedge clk); fuseDisable = 1'b0; #1;
    rdchk("R9 valid cleared", 4'h0, 32'h0000_1008);
    probe("R9 stays off", 32'h0000_0010, 1'b0, 36'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_hit();
    t_lock();
    t_unlock();
    t_zero_size();
    t_top();
    t_wrap36();
    t_fuse();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule